// File: doc/BRIEF.md
# Fully Associative Translation Cache with Used-Bit Replacement

This block caches address translations in a small, fully associative array. Each slot keeps a page-aligned virtual base, a page-size code, a partition number, a context number, a flag that marks the translation as real rather than virtual, a translation data word whose bit 0 acts as a lock, and a valid and a used bit. A lookup port compares a probe against every slot at once. In the same cycle it returns whether a slot hit, which slot it was, and that slot's data word.

A single operation port carries inserts and the three kinds of invalidation. Each takes effect on the next rising clock edge. An insert either names its slot or lets the block choose one from the used bits. Before the new slot is written, any valid slot whose page overlaps the new one under the same partition, context and real flag is removed, so no probe can ever match two slots. A read port returns any slot's tag as a packed 64-bit word for diagnostic read-back.

Top module: `fa_tlb`

## Requirements
- R1: A lookup hits a slot only when the slot is valid and its partition, context and real flag all equal the probe's. The hit flag, slot index and data word appear combinationally in the same cycle.
- R2: The page size is 2^(13+3*code) bytes for the 2-bit size code. A slot matches any probe address that lies in [base, base + page size). The base is the inserted address with the in-page bits cleared.
- R3: An insert (operation code 1) without an explicit index writes the lowest-numbered slot that is invalid or has a clear used bit. If no slot qualifies, it writes the highest-numbered slot.
- R4: A lookup hit, or an insert, sets the used bit of the slot it touched. If every used bit is then set, all used bits except that slot's are cleared.
- R5: An insert with the explicit flag set writes the slot given by the index input and skips the victim search.
- R6: An insert first invalidates every valid slot with the same partition, context and real flag whose page overlaps the new page, judged at the larger of the two page sizes, and clears its used bit.
- R7: Operation code 2 invalidates the slot that a lookup with the operation's address, partition, context and real flag would hit.
- R8: Operation code 3 invalidates every slot whose partition and context both equal the operation's, whatever its real flag.
- R9: Operation code 4 invalidates every slot of the operation's partition whose data bit 0 (lock) is clear. Locked slots and slots of other partitions survive.
- R10: The read-back tag word is laid out as follows: bits 12:0 hold the context ORed with the page base, bits 57:56 hold the inverted size code, bit 60 holds the real flag, and bits 63:61 hold the partition.
- R11: A lookup made in the same cycle as an operation (code 0 is no operation) sees the contents from before that operation.
- R12: After reset every slot is invalid and no lookup hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Operation: 0 none, 1 insert, 2 demap page, 3 demap context, 4 demap partition |
| op_va | input | AW | Operation virtual address |
| op_size | input | 2 | Page-size code for an insert |
| op_part | input | PW | Operation partition |
| op_ctx | input | CW | Operation context |
| op_is_real | input | 1 | Operation real flag |
| op_data | input | DW | Translation data for an insert; bit 0 is the lock |
| op_explicit | input | 1 | Insert into op_index instead of a chosen victim |
| op_index | input | IW | Explicit insert slot |
| lk_en | input | 1 | Lookup probe is active (a hit updates used bits) |
| lk_va | input | AW | Probe address |
| lk_part | input | PW | Probe partition |
| lk_ctx | input | CW | Probe context |
| lk_is_real | input | 1 | Probe real flag |
| lk_hit | output | 1 | A slot matched |
| lk_idx | output | IW | Index of the matching slot |
| lk_data | output | DW | Data word of the matching slot |
| rd_idx | input | IW | Slot to read back |
| rd_tag | output | 64 | Packed tag word of that slot |

## Verification
Probes are aimed at pages of three sizes. Some fall on the first and last byte of a page and on the bytes just outside it, which separates range matching from equality matching. Other probes change only the partition, only the context or only the real flag, which shows that each field takes part in the compare on its own. A chain of inserts and touching lookups is arranged so that the predicted victim slot differs from a naive next-free choice. Each kind of invalidation is then tested with a mix of entries it should remove and entries it should spare: locked, from another partition, or from another context. An overlapping insert is placed in a higher slot than the entry it replaces, so a stale duplicate would win the lookup and be seen.

// File: rtl/fa_tlb_pkg.sv
package fa_tlb_pkg;

    typedef enum logic [2:0] {
        OP_NOP        = 3'd0,
        OP_INSERT     = 3'd1,
        OP_DEMAP_PAGE = 3'd2,
        OP_DEMAP_CTX  = 3'd3,
        OP_DEMAP_PART = 3'd4
    } tlb_op_e;

    localparam int SZW          = 2;   // page-size code width
    localparam int PG_SHIFT_MIN = 13;  // smallest page is 8 KiB
    localparam int PG_SHIFT_INC = 3;   // each size step multiplies by 8
    localparam int TAG_W        = 64;
    localparam int TAG_REAL_BIT = 60;
    localparam int TAG_PART_LSB = 61;
    localparam int TAG_SIZE_LSB = 56;
    localparam int LOCK_BIT     = 0;

endpackage

// File: rtl/tlb_entry_cmp.sv
module tlb_entry_cmp
    import fa_tlb_pkg::*;
#(
    parameter int AW = 40,
    parameter int CW = 13,
    parameter int PW = 3
) (
    input  logic           e_valid,
    input  logic [AW-1:0]  e_base,
    input  logic [SZW-1:0] e_size,
    input  logic [PW-1:0]  e_part,
    input  logic [CW-1:0]  e_ctx,
    input  logic           e_real,
    input  logic           e_lock,
    input  logic [AW-1:0]  lk_va,
    input  logic [PW-1:0]  lk_part,
    input  logic [CW-1:0]  lk_ctx,
    input  logic           lk_real,
    input  logic [AW-1:0]  op_va,
    input  logic [SZW-1:0] op_size,
    input  logic [PW-1:0]  op_part,
    input  logic [CW-1:0]  op_ctx,
    input  logic           op_real,
    output logic           lk_match,
    output logic           op_page_match,
    output logic           op_overlap,
    output logic           op_ctx_match,
    output logic           op_part_unlocked
);

    function automatic logic [AW-1:0] hi_mask(input logic [SZW-1:0] code);
        int sh;
        sh = PG_SHIFT_MIN + PG_SHIFT_INC * int'(code);
        return {AW{1'b1}} << sh;
    endfunction

    logic [AW-1:0] e_hi;
    logic [AW-1:0] op_hi;
    logic [AW-1:0] big_hi;
    logic          lk_id_eq;
    logic          op_id_eq;

    always_comb begin
        e_hi     = hi_mask(e_size);
        op_hi    = hi_mask(op_size);
        big_hi   = (op_size > e_size) ? op_hi : e_hi;
        lk_id_eq = (e_part == lk_part) && (e_ctx == lk_ctx) && (e_real == lk_real);
        op_id_eq = (e_part == op_part) && (e_ctx == op_ctx) && (e_real == op_real);

        lk_match         = e_valid && lk_id_eq && ((lk_va & e_hi) == e_base);
        op_page_match    = e_valid && op_id_eq && ((op_va & e_hi) == e_base);
        op_overlap       = e_valid && op_id_eq && ((op_va & big_hi) == (e_base & big_hi));
        op_ctx_match     = e_valid && (e_part == op_part) && (e_ctx == op_ctx);
        op_part_unlocked = e_valid && (e_part == op_part) && !e_lock;
    end

endmodule

// File: rtl/tlb_first_set.sv
module tlb_first_set #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/tlb_tag_pack.sv
module tlb_tag_pack
    import fa_tlb_pkg::*;
#(
    parameter int AW = 40,
    parameter int CW = 13,
    parameter int PW = 3
) (
    input  logic [AW-1:0]    base,
    input  logic [SZW-1:0]   size,
    input  logic [PW-1:0]    part,
    input  logic [CW-1:0]    ctx,
    input  logic             is_real,
    output logic [TAG_W-1:0] tag
);

    always_comb begin
        tag                       = '0;
        tag[AW-1:0]               = base;
        tag[CW-1:0]               = tag[CW-1:0] | ctx;
        tag[TAG_SIZE_LSB +: SZW]  = ~size;
        tag[TAG_REAL_BIT]         = is_real;
        tag[TAG_PART_LSB +: PW]   = part;
    end

endmodule

// File: rtl/fa_tlb.sv
module fa_tlb
    import fa_tlb_pkg::*;
#(
    parameter int    N_ENTRIES = 16,
    parameter int    AW        = 40,
    parameter int    CW        = 13,
    parameter int    PW        = 3,
    parameter int    DW        = 32,
    localparam int   IW        = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       op,
    input  logic [AW-1:0]    op_va,
    input  logic [SZW-1:0]   op_size,
    input  logic [PW-1:0]    op_part,
    input  logic [CW-1:0]    op_ctx,
    input  logic             op_is_real,
    input  logic [DW-1:0]    op_data,
    input  logic             op_explicit,
    input  logic [IW-1:0]    op_index,
    input  logic             lk_en,
    input  logic [AW-1:0]    lk_va,
    input  logic [PW-1:0]    lk_part,
    input  logic [CW-1:0]    lk_ctx,
    input  logic             lk_is_real,
    output logic             lk_hit,
    output logic [IW-1:0]    lk_idx,
    output logic [DW-1:0]    lk_data,
    input  logic [IW-1:0]    rd_idx,
    output logic [TAG_W-1:0] rd_tag
);

    if (N_ENTRIES > 64 || N_ENTRIES < 1) begin : g_bad_depth
        $error("fa_tlb: N_ENTRIES must lie between 1 and 64");
    end
    if (AW > TAG_SIZE_LSB || CW > PG_SHIFT_MIN || PW > 3) begin : g_bad_widths
        $error("fa_tlb: field widths do not fit the tag word");
    end

    localparam logic [IW-1:0] LAST_IDX = IW'(N_ENTRIES - 1);

    typedef struct packed {
        logic           valid;
        logic           used;
        logic [AW-1:0]  base;
        logic [SZW-1:0] size;
        logic [PW-1:0]  part;
        logic [CW-1:0]  ctx;
        logic           is_real;
        logic [DW-1:0]  data;
    } slot_t;

    typedef struct packed {
        slot_t [N_ENTRIES-1:0] slot;
    } state_t;

    state_t st_d, st_q;

    tlb_op_e op_e;
    assign op_e = tlb_op_e'(op);

    // ---------------------------------------------------------------
    // Per-slot comparison
    // ---------------------------------------------------------------
    logic [N_ENTRIES-1:0] lk_hit_vec;
    logic [N_ENTRIES-1:0] pg_vec;
    logic [N_ENTRIES-1:0] ovl_vec;
    logic [N_ENTRIES-1:0] ctx_vec;
    logic [N_ENTRIES-1:0] part_vec;
    logic [N_ENTRIES-1:0] free_vec;
    logic [N_ENTRIES-1:0] valid_vec;
    logic [N_ENTRIES-1:0] used_vec;

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
        tlb_entry_cmp #(.AW(AW), .CW(CW), .PW(PW)) u_cmp (
            .e_valid         (st_q.slot[g].valid),
            .e_base          (st_q.slot[g].base),
            .e_size          (st_q.slot[g].size),
            .e_part          (st_q.slot[g].part),
            .e_ctx           (st_q.slot[g].ctx),
            .e_real          (st_q.slot[g].is_real),
            .e_lock          (st_q.slot[g].data[LOCK_BIT]),
            .lk_va           (lk_va),
            .lk_part         (lk_part),
            .lk_ctx          (lk_ctx),
            .lk_real         (lk_is_real),
            .op_va           (op_va),
            .op_size         (op_size),
            .op_part         (op_part),
            .op_ctx          (op_ctx),
            .op_real         (op_is_real),
            .lk_match        (lk_hit_vec[g]),
            .op_page_match   (pg_vec[g]),
            .op_overlap      (ovl_vec[g]),
            .op_ctx_match    (ctx_vec[g]),
            .op_part_unlocked(part_vec[g])
        );
        assign valid_vec[g] = st_q.slot[g].valid;
        assign used_vec[g]  = st_q.slot[g].used;
        assign free_vec[g]  = !st_q.slot[g].valid || !st_q.slot[g].used;
    end

    // ---------------------------------------------------------------
    // Hit and victim selection
    // ---------------------------------------------------------------
    logic          free_any;
    logic [IW-1:0] free_idx;
    logic [IW-1:0] victim_idx;
    logic [IW-1:0] ins_tgt;
    logic          ins_ok;

    tlb_first_set #(.N(N_ENTRIES), .IW(IW)) u_hit_sel (
        .vec (lk_hit_vec),
        .any (lk_hit),
        .idx (lk_idx)
    );

    tlb_first_set #(.N(N_ENTRIES), .IW(IW)) u_free_sel (
        .vec (free_vec),
        .any (free_any),
        .idx (free_idx)
    );

    assign victim_idx = free_any ? free_idx : LAST_IDX;
    assign ins_tgt    = op_explicit ? op_index : victim_idx;
    assign ins_ok     = !op_explicit || (int'(op_index) < N_ENTRIES);
    assign lk_data    = st_q.slot[lk_idx].data;

    // ---------------------------------------------------------------
    // Tag read-back
    // ---------------------------------------------------------------
    logic [IW-1:0] rd_sel;
    assign rd_sel = (int'(rd_idx) < N_ENTRIES) ? rd_idx : '0;

    tlb_tag_pack #(.AW(AW), .CW(CW), .PW(PW)) u_tag (
        .base    (st_q.slot[rd_sel].base),
        .size    (st_q.slot[rd_sel].size),
        .part    (st_q.slot[rd_sel].part),
        .ctx     (st_q.slot[rd_sel].ctx),
        .is_real (st_q.slot[rd_sel].is_real),
        .tag     (rd_tag)
    );

    // ---------------------------------------------------------------
    // Next state
    // ---------------------------------------------------------------
    function automatic state_t age_used(input state_t s, input logic [IW-1:0] keep);
        state_t r;
        logic   full;
        r    = s;
        full = 1'b1;
        for (int i = 0; i < N_ENTRIES; i++) begin
            full = full & s.slot[i].used;
        end
        if (full) begin
            for (int i = 0; i < N_ENTRIES; i++) begin
                r.slot[i].used = (i == int'(keep));
            end
        end
        return r;
    endfunction

    logic [AW-1:0] ins_base;
    always_comb begin
        ins_base = op_va & ({AW{1'b1}} << (PG_SHIFT_MIN + PG_SHIFT_INC * int'(op_size)));
    end

    always_comb begin
        st_d = st_q;
        case (op_e)
            OP_NOP: begin
                if (lk_en && lk_hit) begin
                    st_d.slot[lk_idx].used = 1'b1;
                    st_d = age_used(st_d, lk_idx);
                end
            end
            OP_INSERT: begin
                if (ins_ok) begin
                    for (int i = 0; i < N_ENTRIES; i++) begin
                        if (ovl_vec[i]) begin
                            st_d.slot[i].valid = 1'b0;
                            st_d.slot[i].used  = 1'b0;
                        end
                    end
                    st_d.slot[ins_tgt] = '{valid:   1'b1,
                                           used:    1'b1,
                                           base:    ins_base,
                                           size:    op_size,
                                           part:    op_part,
                                           ctx:     op_ctx,
                                           is_real: op_is_real,
                                           data:    op_data};
                    st_d = age_used(st_d, ins_tgt);
                end
            end
            OP_DEMAP_PAGE: begin
                for (int i = 0; i < N_ENTRIES; i++) begin
                    if (pg_vec[i]) begin
                        st_d.slot[i].valid = 1'b0;
                        st_d.slot[i].used  = 1'b0;
                    end
                end
            end
            OP_DEMAP_CTX: begin
                for (int i = 0; i < N_ENTRIES; i++) begin
                    if (ctx_vec[i]) begin
                        st_d.slot[i].valid = 1'b0;
                        st_d.slot[i].used  = 1'b0;
                    end
                end
            end
            OP_DEMAP_PART: begin
                for (int i = 0; i < N_ENTRIES; i++) begin
                    if (part_vec[i]) begin
                        st_d.slot[i].valid = 1'b0;
                        st_d.slot[i].used  = 1'b0;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/fa_tlb_chk.sv
module fa_tlb_chk #(
    parameter int N_ENTRIES = 16,
    parameter int IW        = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic [2:0]           op,
    input logic                 op_explicit,
    input logic [N_ENTRIES-1:0] lk_hit_vec,
    input logic [N_ENTRIES-1:0] valid_vec,
    input logic [N_ENTRIES-1:0] used_vec,
    input logic [IW-1:0]        victim_idx
);

    // R6: overlap removal keeps every probe down to at most one matching slot
    a_r6_single_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_hit_vec));

    // R4: a used bit is never left on a slot that is invalid
    a_r4_used_needs_valid: assert property (@(posedge clk) disable iff (rst)
        (used_vec & ~valid_vec) == '0);

    // R4: saturation clearing never leaves all used bits set
    a_r4_never_saturated: assert property (@(posedge clk) disable iff (rst)
        (N_ENTRIES == 1) || ($countones(used_vec) < N_ENTRIES));

    // R3: an automatic insert leaves its chosen victim valid and used
    a_r3_victim_filled: assert property (@(posedge clk) disable iff (rst)
        (op == 3'd1 && !op_explicit) |=> (valid_vec[$past(victim_idx)] && used_vec[$past(victim_idx)]));

    // R12: the first cycle after reset finds every slot empty
    a_r12_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (valid_vec == '0));

endmodule

bind fa_tlb fa_tlb_chk #(.N_ENTRIES(N_ENTRIES), .IW(IW)) u_fa_tlb_chk (
    .clk         (clk),
    .rst         (rst),
    .op          (op),
    .op_explicit (op_explicit),
    .lk_hit_vec  (lk_hit_vec),
    .valid_vec   (valid_vec),
    .used_vec    (used_vec),
    .victim_idx  (victim_idx)
);

// File: tb/fa_tlb_tb_top.sv
module fa_tlb_tb_top;

    localparam int N  = 4;
    localparam int AW = 40;
    localparam int CW = 13;
    localparam int PW = 3;
    localparam int DW = 32;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    op = '0;
    logic [AW-1:0] op_va = '0;
    logic [1:0]    op_size = '0;
    logic [PW-1:0] op_part = '0;
    logic [CW-1:0] op_ctx = '0;
    logic          op_is_real = 1'b0;
    logic [DW-1:0] op_data = '0;
    logic          op_explicit = 1'b0;
    logic [IW-1:0] op_index = '0;
    logic          lk_en = 1'b0;
    logic [AW-1:0] lk_va = '0;
    logic [PW-1:0] lk_part = '0;
    logic [CW-1:0] lk_ctx = '0;
    logic          lk_is_real = 1'b0;
    logic          lk_hit;
    logic [IW-1:0] lk_idx;
    logic [DW-1:0] lk_data;
    logic [IW-1:0] rd_idx = '0;
    logic [63:0]   rd_tag;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    fa_tlb #(.N_ENTRIES(N), .AW(AW), .CW(CW), .PW(PW), .DW(DW)) dut_i (
        .clk(clk), .rst(rst), .op(op), .op_va(op_va), .op_size(op_size),
        .op_part(op_part), .op_ctx(op_ctx), .op_is_real(op_is_real),
        .op_data(op_data), .op_explicit(op_explicit), .op_index(op_index),
        .lk_en(lk_en), .lk_va(lk_va), .lk_part(lk_part), .lk_ctx(lk_ctx),
        .lk_is_real(lk_is_real), .lk_hit(lk_hit), .lk_idx(lk_idx),
        .lk_data(lk_data), .rd_idx(rd_idx), .rd_tag(rd_tag)
    );

    typedef struct packed {
        logic [AW-1:0] va;
        logic [PW-1:0] part;
        logic [CW-1:0] ctx;
        logic          rl;
        logic          hit;
        logic [IW-1:0] idx;
        logic [DW-1:0] data;
    } probe_t;

    // Probes against the three preloaded pages (R1 fields, R2 ranges)
    localparam probe_t PROBES [11] = '{
        '{40'h2abc,   3'd1, 13'd5, 1'b0, 1'b1, 2'd0, 32'h100},
        '{40'h1fff,   3'd1, 13'd5, 1'b0, 1'b0, 2'd0, 32'h0},
        '{40'h4000,   3'd1, 13'd5, 1'b0, 1'b0, 2'd0, 32'h0},
        '{40'h2abc,   3'd1, 13'd6, 1'b0, 1'b0, 2'd0, 32'h0},
        '{40'h2abc,   3'd2, 13'd5, 1'b0, 1'b0, 2'd0, 32'h0},
        '{40'h2abc,   3'd1, 13'd5, 1'b1, 1'b0, 2'd0, 32'h0},
        '{40'h7ffff8, 3'd1, 13'd5, 1'b0, 1'b1, 2'd1, 32'h201},
        '{40'h400000, 3'd1, 13'd5, 1'b0, 1'b1, 2'd1, 32'h201},
        '{40'h800000, 3'd1, 13'd5, 1'b0, 1'b0, 2'd0, 32'h0},
        '{40'h1fffc,  3'd2, 13'd0, 1'b1, 1'b1, 2'd2, 32'h300},
        '{40'h20000,  3'd2, 13'd0, 1'b1, 1'b0, 2'd0, 32'h0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic [2:0] code, input logic [AW-1:0] va, input logic [1:0] sz,
                         input logic [PW-1:0] pt, input logic [CW-1:0] cx, input logic rl,
                         input logic [DW-1:0] dt, input logic ex, input logic [IW-1:0] ix);
        @(negedge clk);
        op = code; op_va = va; op_size = sz; op_part = pt; op_ctx = cx;
        op_is_real = rl; op_data = dt; op_explicit = ex; op_index = ix;
        @(negedge clk);
        op = 3'd0; op_explicit = 1'b0;
    endtask

    // Lookup held across one rising edge, so a hit touches the used bit
    task automatic look(input string req, input logic [AW-1:0] va, input logic [PW-1:0] pt,
                        input logic [CW-1:0] cx, input logic rl, input logic eh,
                        input logic [IW-1:0] ei, input logic [DW-1:0] ed);
        @(negedge clk);
        lk_en = 1'b1; lk_va = va; lk_part = pt; lk_ctx = cx; lk_is_real = rl;
        #2;
        chk(req, 64'(lk_hit), 64'(eh));
        if (eh) begin
            chk(req, 64'(lk_idx), 64'(ei));
            chk(req, 64'(lk_data), 64'(ed));
        end
        @(posedge clk);
        #1 lk_en = 1'b0;
    endtask

    task automatic tag(input string req, input logic [IW-1:0] ix, input logic [63:0] exp);
        @(negedge clk);
        rd_idx = ix;
        #2 chk(req, rd_tag, exp);
    endtask

    bit finished = 1'b0;

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R12: empty after reset, all-zero probe still misses
        look("R12 reset", 40'h0, 3'd0, 13'd0, 1'b0, 1'b0, 2'd0, 32'h0);
        tag("R12 R10 reset tag", 2'd0, 64'h0300_0000_0000_0000);

        // Preload three pages through automatic inserts (R3 lowest free)
        do_op(3'd1, 40'h2000,   2'd0, 3'd1, 13'd5, 1'b0, 32'h100, 1'b0, 2'd0);
        do_op(3'd1, 40'h401234, 2'd3, 3'd1, 13'd5, 1'b0, 32'h201, 1'b0, 2'd0);
        do_op(3'd1, 40'h10000,  2'd1, 3'd2, 13'd0, 1'b1, 32'h300, 1'b0, 2'd0);

        for (int k = 0; k < 11; k++) begin
            look("R1 R2 probe table", PROBES[k].va, PROBES[k].part, PROBES[k].ctx, PROBES[k].rl,
                 PROBES[k].hit, PROBES[k].idx, PROBES[k].data);
        end

        // R10 / R2: tag layout with an aligned base
        tag("R10 R2 tag slot1", 2'd1, 64'h2000_0000_0040_0005);
        tag("R10 tag slot2",    2'd2, 64'h5200_0000_0001_0000);

        // R3 R4: fill slot 3, saturation leaves only slot 3 used, next goes to slot 0
        do_op(3'd1, 40'h6000, 2'd0, 3'd1, 13'd7, 1'b0, 32'h400, 1'b0, 2'd0);
        do_op(3'd1, 40'h8000, 2'd0, 3'd1, 13'd7, 1'b0, 32'h500, 1'b0, 2'd0);
        look("R3 R4 old slot0 evicted", 40'h2abc, 3'd1, 13'd5, 1'b0, 1'b0, 2'd0, 32'h0);
        look("R3 R4 victim slot0",      40'h8000, 3'd1, 13'd7, 1'b0, 1'b1, 2'd0, 32'h500);

        // R4: a touching lookup on slot 1 steers the next victim to slot 2
        look("R4 touch slot1", 40'h400000, 3'd1, 13'd5, 1'b0, 1'b1, 2'd1, 32'h201);
        do_op(3'd1, 40'hA000, 2'd0, 3'd1, 13'd7, 1'b0, 32'h600, 1'b0, 2'd0);
        look("R4 victim slot2", 40'hA000, 3'd1, 13'd7, 1'b0, 1'b1, 2'd2, 32'h600);

        // R5: explicit slot 1
        do_op(3'd1, 40'hC000, 2'd0, 3'd3, 13'd9, 1'b0, 32'h700, 1'b1, 2'd1);
        look("R5 overwritten gone", 40'h400000, 3'd1, 13'd5, 1'b0, 1'b0, 2'd0, 32'h0);
        look("R5 explicit slot1",   40'hC000,   3'd3, 13'd9, 1'b0, 1'b1, 2'd1, 32'h700);

        // R6: same page into slot 3 removes the copy in slot 2
        do_op(3'd1, 40'hA000, 2'd0, 3'd1, 13'd7, 1'b0, 32'h800, 1'b1, 2'd3);
        look("R6 duplicate removed", 40'hA000, 3'd1, 13'd7, 1'b0, 1'b1, 2'd3, 32'h800);

        // R11: lookup in the insert cycle sees the old contents
        @(negedge clk);
        op = 3'd1; op_va = 40'hE000; op_size = 2'd0; op_part = 3'd1; op_ctx = 13'd7;
        op_is_real = 1'b0; op_data = 32'h900; op_explicit = 1'b0;
        lk_en = 1'b1; lk_va = 40'hE000; lk_part = 3'd1; lk_ctx = 13'd7; lk_is_real = 1'b0;
        #2 chk("R11 pre-insert view", 64'(lk_hit), 64'd0);
        @(negedge clk);
        op = 3'd0; lk_en = 1'b0;
        look("R11 R3 after insert", 40'hE000, 3'd1, 13'd7, 1'b0, 1'b1, 2'd0, 32'h900);

        // R7: page demap by an inner address
        do_op(3'd2, 40'hC123, 2'd0, 3'd3, 13'd9, 1'b0, 32'h0, 1'b0, 2'd0);
        look("R7 page gone",     40'hC000, 3'd3, 13'd9, 1'b0, 1'b0, 2'd0, 32'h0);
        look("R7 other kept",    40'hE000, 3'd1, 13'd7, 1'b0, 1'b1, 2'd0, 32'h900);

        // R8: context demap spares another partition with the same context
        do_op(3'd1, 40'h2000, 2'd0, 3'd2, 13'd7, 1'b0, 32'hA00, 1'b0, 2'd0);
        do_op(3'd3, 40'h0, 2'd0, 3'd1, 13'd7, 1'b0, 32'h0, 1'b0, 2'd0);
        look("R8 ctx slot0 gone", 40'hE000, 3'd1, 13'd7, 1'b0, 1'b0, 2'd0, 32'h0);
        look("R8 ctx slot3 gone", 40'hA000, 3'd1, 13'd7, 1'b0, 1'b0, 2'd0, 32'h0);
        look("R8 other part kept", 40'h2000, 3'd2, 13'd7, 1'b0, 1'b1, 2'd1, 32'hA00);

        // R9: partition demap spares locked and foreign slots
        do_op(3'd1, 40'h4000, 2'd0, 3'd2, 13'd8, 1'b0, 32'hB01, 1'b1, 2'd2);
        do_op(3'd1, 40'h4000, 2'd0, 3'd3, 13'd1, 1'b0, 32'hC00, 1'b1, 2'd0);
        do_op(3'd4, 40'h0, 2'd0, 3'd2, 13'd0, 1'b0, 32'h0, 1'b0, 2'd0);
        look("R9 unlocked gone",  40'h2000, 3'd2, 13'd7, 1'b0, 1'b0, 2'd0, 32'h0);
        look("R9 locked kept",    40'h4000, 3'd2, 13'd8, 1'b0, 1'b1, 2'd2, 32'hB01);
        look("R9 foreign kept",   40'h4000, 3'd3, 13'd1, 1'b0, 1'b1, 2'd0, 32'hC00);
        tag("R10 tag slot2 new",  2'd2, 64'h4300_0000_0000_4008);
        tag("R10 tag slot0 new",  2'd0, 64'h6300_0000_0000_4001);

        // R6: a large page swallows a small page in slot 0, lands in free slot 1
        do_op(3'd1, 40'h0, 2'd3, 3'd3, 13'd1, 1'b0, 32'hD00, 1'b0, 2'd0);
        look("R6 large overlap", 40'h4000, 3'd3, 13'd1, 1'b0, 1'b1, 2'd1, 32'hD00);

        // R12: reset mid-run clears everything
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        look("R12 reset clears", 40'h4000, 3'd2, 13'd8, 1'b0, 1'b0, 2'd0, 32'h0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule